// File: doc/BRIEF.md
# Synchronised PWM Current Chopper

This block drives the single high-side chopping switch of a unipolar stepper output stage. A digital period counter stands in for the RC oscillator. Each new period sets an on/off latch that turns the switch on, and a blanking window at the start of each period masks the current comparator. In closed loop, the switch stays on until the synchronised comparator input reports that the sense voltage has reached the reference, after the window has elapsed. In open loop, the comparator is ignored and the switch stays on for a fixed fraction of the window. A rate bit makes the closed-loop period twice as long.

A phase-change pulse from the step sequencer starts a new period at once and turns the switch on. The chopping therefore stays in step with the winding commutation, and no beat forms between the two rates. While the high-side switch is off, the block asserts a low-side assist output so the opposite winding half can carry the decaying current. The block also outputs the comparator reference level, in millivolts, that the current request selects. A disable input covers reset, programming and illegal input patterns: it turns both switches off and parks the counter.

Top module: `step_chopper`

## Requirements
- R1: While `drive_off_i` is high, `hs_on_o`, `ls_assist_o` and `period_tick_o` are low from the next clock edge on. On the first clock edge after the input falls, a new period starts: `period_tick_o` and `hs_on_o` are both high in that cycle.
- R2: In closed loop (`open_loop_i` low, `half_rate_i` low), a period lasts PERIOD_CYC cycles. `period_tick_o` is high for exactly the first cycle of each period, and `hs_on_o` is high in that cycle.
- R3: In closed loop with `half_rate_i` high, a period lasts 2·PERIOD_CYC cycles. In open loop, `half_rate_i` has no effect and the period stays PERIOD_CYC.
- R4: In closed loop, a comparator trip within the first WINDOW_CYC cycles of a period is ignored. With the trip held high, the switch is on for exactly WINDOW_CYC cycles per period.
- R5: The comparator input passes through a two-stage synchroniser. A trip that rises in period cycle k (k ≥ WINDOW_CYC−2) gives an on time of k+3 cycles. With no trip, the switch stays on for the whole period.
- R6: In open loop, the comparator is ignored and `on_code_i` sets the on time: 0 → 3·WINDOW_CYC/4, 1 → WINDOW_CYC, 2 → WINDOW_CYC/2, and 3 → never on.
- R7: `ls_assist_o` is high exactly in the cycles where the block is enabled, the switch is off and open-loop code 3 is not selected. It is never high together with `hs_on_o`.
- R8: When `phase_step_i` is high at a clock edge, the current period ends and a new one begins in the next cycle, with the counter at zero, `period_tick_o` high and the switch on. The restart also applies mid-period.
- R9: One cycle after the inputs change, `ref_mv_o` reads 500 if `reduce_i` is low. If `reduce_i` is high, it reads 200, 250, 350 or 425 for `level_code_i` = 0, 1, 2 or 3. The reset value is 500.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| drive_off_i | input | 1 | Forces both switches off and parks the period counter |
| open_loop_i | input | 1 | 1 = open loop (fixed on time), 0 = closed loop |
| half_rate_i | input | 1 | 1 = doubled closed-loop period |
| on_code_i | input | 2 | Open-loop on-time code |
| level_code_i | input | 2 | Reduced reference level code |
| reduce_i | input | 1 | Request for the reduced reference level |
| phase_step_i | input | 1 | Phase-change pulse; restarts the period |
| trip_i | input | 1 | Asynchronous current comparator output |
| hs_on_o | output | 1 | High-side chopping switch drive |
| ls_assist_o | output | 1 | Low-side assist drive during off time |
| period_tick_o | output | 1 | High in the first cycle of each period |
| ref_mv_o | output | 10 | Selected comparator reference in millivolts |

## Verification
The embedded assertions check four properties on every cycle:
- The two switch outputs never overlap.
- The disable input empties the counter and turns the switch off.
- A phase pulse always yields a zeroed counter with the switch on.
- A closed-loop on phase cannot end inside the blanking window.

Other properties depend on whole periods of input history, and only the bench scenarios show them:
- The exact on-time and period lengths for each open-loop code and for both rates.
- The on-time shift that comparator synchronisation adds to a mid-period trip.
- The shortened period that a mid-period phase restart leaves behind.

// File: rtl/step_chopper_pkg.sv
package step_chopper_pkg;

    localparam int MV_W       = 10;
    localparam int NOMINAL_MV = 500;

    typedef enum logic [1:0] {
        DUTY_3Q   = 2'd0,
        DUTY_FULL = 2'd1,
        DUTY_HALF = 2'd2,
        DUTY_OFF  = 2'd3
    } duty_code_e;

    // reference level in millivolts for a reduction request and level code
    function automatic logic [MV_W-1:0] level_mv(input logic reduce, input logic [1:0] code);
        int pct;
        if (!reduce) begin
            pct = 100;
        end else begin
            case (code)
                2'd0:    pct = 40;
                2'd1:    pct = 50;
                2'd2:    pct = 70;
                default: pct = 85;
            endcase
        end
        return MV_W'((NOMINAL_MV * pct) / 100);
    endfunction

endpackage

// File: rtl/chop_sync.sv
module chop_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);

    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_s;

    sync_s st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[STAGES-2:0], async_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_o = st_q.chain[STAGES-1];

endmodule

// File: rtl/chop_osc.sv
module chop_osc #(
    parameter int PERIOD_CYC = 50,
    parameter int CW         = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          disable_i,
    input  logic          restart_i,
    input  logic          double_i,
    output logic          start_o,
    output logic [CW-1:0] cnt_o,
    output logic          tick_o
);

    localparam logic [CW-1:0] LAST_SGL = CW'(PERIOD_CYC - 1);
    localparam logic [CW-1:0] LAST_DBL = CW'(2 * PERIOD_CYC - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          tick;
        logic          parked;
    } osc_s;

    osc_s          st_d, st_q;
    logic [CW-1:0] last;
    logic          start;

    always_comb begin
        st_d        = st_q;
        last        = double_i ? LAST_DBL : LAST_SGL;
        // a period begins after a park, on a phase change or at wrap
        start       = !disable_i && (restart_i || st_q.parked || (st_q.cnt >= last));
        st_d.parked = disable_i;
        st_d.tick   = start;
        st_d.cnt    = (disable_i || start) ? '0 : st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{cnt: '0, tick: 1'b0, parked: 1'b1};
        else        st_q <= st_d;
    end

    assign start_o = start;
    assign cnt_o   = st_q.cnt;
    assign tick_o  = st_q.tick;

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LAST_DBL) else $error("counter beyond longest period"); // R3

    AST_PARK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        disable_i |=> (st_q.cnt == '0 && !st_q.tick)) else $error("counter not parked"); // R1

    AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (restart_i && !disable_i) |=> (st_q.cnt == '0 && st_q.tick)) else $error("phase restart missed"); // R8

endmodule

// File: rtl/chop_ref.sv
module chop_ref
    import step_chopper_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reduce_i,
    input  logic [1:0]      level_code_i,
    output logic [MV_W-1:0] lvl_o
);

    typedef struct packed {
        logic [MV_W-1:0] lvl;
    } ref_s;

    ref_s st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.lvl = level_mv(reduce_i, level_code_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{lvl: MV_W'(NOMINAL_MV)};
        else        st_q <= st_d;
    end

    assign lvl_o = st_q.lvl;

    AST_REF_NOMINAL: assert property (@(posedge clk) disable iff (!rst_n)
        !reduce_i |=> (lvl_o == MV_W'(NOMINAL_MV))) else $error("nominal level lost"); // R9

endmodule

// File: rtl/chop_gate.sv
module chop_gate
    import step_chopper_pkg::*;
#(
    parameter int WINDOW_CYC = 8,
    parameter int CW         = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          disable_i,
    input  logic          open_i,
    input  logic [1:0]    duty_code_i,
    input  logic          start_i,
    input  logic [CW-1:0] cnt_i,
    input  logic          trip_i,
    output logic          hs_o,
    output logic          assist_o
);

    localparam int            OW        = CW + 1;
    localparam logic [OW-1:0] ON_3Q     = OW'((WINDOW_CYC * 3) / 4);
    localparam logic [OW-1:0] ON_FULL   = OW'(WINDOW_CYC);
    localparam logic [OW-1:0] ON_HALF   = OW'(WINDOW_CYC / 2);
    localparam logic [CW-1:0] BLANK_END = CW'(WINDOW_CYC - 1);

    typedef struct packed {
        logic hs;
        logic assist;
    } gate_s;

    gate_s         st_d, st_q;
    logic [OW-1:0] on_len;
    logic [OW-1:0] cnt_nxt;
    logic          drive_ok;
    logic          blank_over;
    logic          hs_closed;
    logic          hs_open;

    always_comb begin
        case (duty_code_e'(duty_code_i))
            DUTY_3Q:   on_len = ON_3Q;
            DUTY_FULL: on_len = ON_FULL;
            DUTY_HALF: on_len = ON_HALF;
            default:   on_len = '0;
        endcase
    end

    always_comb begin
        st_d       = st_q;
        cnt_nxt    = {1'b0, cnt_i} + OW'(1);
        drive_ok   = !(open_i && duty_code_e'(duty_code_i) == DUTY_OFF);
        blank_over = (cnt_i >= BLANK_END);
        // set dominates: a new period always turns the switch on
        hs_closed  = start_i || (st_q.hs && !(trip_i && blank_over));
        hs_open    = start_i ? (on_len != '0) : (st_q.hs && (cnt_nxt < on_len));
        st_d.hs     = !disable_i && (open_i ? hs_open : hs_closed);
        st_d.assist = !disable_i && drive_ok && !st_d.hs;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hs_o     = st_q.hs;
    assign assist_o = st_q.assist;

    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.hs && st_q.assist)) else $error("switch overlap"); // R7

    AST_OFF_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        disable_i |=> (!st_q.hs && !st_q.assist)) else $error("drive while disabled"); // R1

    AST_BLANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.hs && !open_i && !disable_i && cnt_i < BLANK_END) |=> st_q.hs) else $error("on phase cut in window"); // R4

    AST_OPEN_OFF_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (open_i && duty_code_e'(duty_code_i) == DUTY_OFF) |=> !st_q.hs) else $error("switch on with off code"); // R6

endmodule

// File: rtl/step_chopper.sv
module step_chopper
    import step_chopper_pkg::*;
#(
    parameter int PERIOD_CYC  = 50,
    parameter int WINDOW_CYC  = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            drive_off_i,
    input  logic            open_loop_i,
    input  logic            half_rate_i,
    input  logic [1:0]      on_code_i,
    input  logic [1:0]      level_code_i,
    input  logic            reduce_i,
    input  logic            phase_step_i,
    input  logic            trip_i,
    output logic            hs_on_o,
    output logic            ls_assist_o,
    output logic            period_tick_o,
    output logic [MV_W-1:0] ref_mv_o
);

    // WINDOW_CYC must lie in 2..PERIOD_CYC, SYNC_STAGES must be at least 2
    localparam int CW = $clog2(2 * PERIOD_CYC);

    logic          trip_s;
    logic          start;
    logic [CW-1:0] cnt;

    chop_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (trip_i),
        .sync_o  (trip_s)
    );

    chop_osc #(.PERIOD_CYC(PERIOD_CYC), .CW(CW)) u_osc (
        .clk       (clk),
        .rst_n     (rst_n),
        .disable_i (drive_off_i),
        .restart_i (phase_step_i),
        .double_i  (half_rate_i && !open_loop_i),
        .start_o   (start),
        .cnt_o     (cnt),
        .tick_o    (period_tick_o)
    );

    chop_gate #(.WINDOW_CYC(WINDOW_CYC), .CW(CW)) u_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .disable_i   (drive_off_i),
        .open_i      (open_loop_i),
        .duty_code_i (on_code_i),
        .start_i     (start),
        .cnt_i       (cnt),
        .trip_i      (trip_s),
        .hs_o        (hs_on_o),
        .assist_o    (ls_assist_o)
    );

    chop_ref u_ref (
        .clk          (clk),
        .rst_n        (rst_n),
        .reduce_i     (reduce_i),
        .level_code_i (level_code_i),
        .lvl_o        (ref_mv_o)
    );

    AST_PHASE_TURNS_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_step_i && !drive_off_i && !(open_loop_i && on_code_i == DUTY_OFF)) |=> (hs_on_o && period_tick_o))
        else $error("phase change did not restart chopping"); // R8

    AST_TICK_WITH_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (period_tick_o && !open_loop_i) |-> hs_on_o) else $error("closed-loop period began off"); // R2

endmodule

// File: tb/step_chopper_bench.sv
module step_chopper_bench;

    localparam int P = 20;
    localparam int W = 8;

    typedef struct {
        int    on;
        int    len;
        int    assist;
        string req;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       drive_off_i = 1'b0;
    logic       open_loop_i = 1'b0;
    logic       half_rate_i = 1'b0;
    logic [1:0] on_code_i = 2'd0;
    logic [1:0] level_code_i = 2'd0;
    logic       reduce_i = 1'b0;
    logic       phase_step_i = 1'b0;
    logic       trip_i = 1'b1;
    logic       hs_on_o;
    logic       ls_assist_o;
    logic       period_tick_o;
    logic [9:0] ref_mv_o;

    int   n_checks = 0;
    int   n_fails  = 0;
    int   wd_cnt   = 0;
    exp_t sb_q[$];

    always #5 clk = ~clk;

    step_chopper #(.PERIOD_CYC(P), .WINDOW_CYC(W)) u_step_chopper (
        .clk           (clk),
        .rst_n         (rst_n),
        .drive_off_i   (drive_off_i),
        .open_loop_i   (open_loop_i),
        .half_rate_i   (half_rate_i),
        .on_code_i     (on_code_i),
        .level_code_i  (level_code_i),
        .reduce_i      (reduce_i),
        .phase_step_i  (phase_step_i),
        .trip_i        (trip_i),
        .hs_on_o       (hs_on_o),
        .ls_assist_o   (ls_assist_o),
        .period_tick_o (period_tick_o),
        .ref_mv_o      (ref_mv_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic expect_period(input int on, input int len, input int assist, input string req);
        exp_t it;
        it.on = on; it.len = len; it.assist = assist; it.req = req;
        sb_q.push_back(it);
    endtask

    // returns 2 ns after the edge that opens a period
    task automatic wait_tick();
        bit seen = 1'b0;
        while (!seen) begin
            @(posedge clk); #2;
            seen = period_tick_o;
        end
    endtask

    task automatic settle();
        wait_tick(); wait_tick(); wait_tick();
    endtask

    task automatic drain();
        while (sb_q.size() != 0) @(posedge clk);
    endtask

    // monitor: measures each period from tick to tick and scores it
    bit armed = 1'b0;
    int m_on = 0, m_len = 0, m_as = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (period_tick_o) begin
                if (armed && sb_q.size() != 0) begin
                    exp_t e;
                    e = sb_q.pop_front();
                    n_checks++;
                    if (m_on != e.on || m_len != e.len || m_as != e.assist) begin
                        n_fails++;
                        $display("FAIL %s: actual on/len/assist %0d/%0d/%0d expected %0d/%0d/%0d",
                                 e.req, m_on, m_len, m_as, e.on, e.len, e.assist);
                    end
                end
                armed = (sb_q.size() != 0);
                m_on  = int'(hs_on_o);
                m_as  = int'(ls_assist_o);
                m_len = 1;
            end else begin
                m_on  += int'(hs_on_o);
                m_as  += int'(ls_assist_o);
                m_len += 1;
            end
        end
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    endtask

    always @(posedge clk) begin
        wd_cnt++;
        if (wd_cnt > 150000) begin
            n_fails++;
            $display("FAIL watchdog: actual %0d expected below %0d", wd_cnt, 150000);
            summary();
            $finish;
        end
    end

    initial begin
        int on_tab[4];
        int mv_tab[4];
        on_tab[0] = (W * 3) / 4; on_tab[1] = W; on_tab[2] = W / 2; on_tab[3] = 0;
        mv_tab[0] = 200; mv_tab[1] = 250; mv_tab[2] = 350; mv_tab[3] = 425;

        // reset state (R1, R9)
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(hs_on_o == 1'b0, "R1 reset hs", int'(hs_on_o), 0);
        check(ls_assist_o == 1'b0 && period_tick_o == 1'b0, "R1 reset assist/tick",
              int'({ls_assist_o, period_tick_o}), 0);
        check(ref_mv_o == 10'd500, "R9 reset ref", int'(ref_mv_o), 500);
        @(posedge clk); #2 rst_n = 1'b1;

        // closed loop, trip held: on time equals the window (R2, R4, R10-free tick check via length)
        settle();
        expect_period(W, P, P - W, "R2");
        expect_period(W, P, P - W, "R4");
        expect_period(W, P, P - W, "R7");
        drain();

        // doubled period (R3)
        half_rate_i = 1'b1;
        settle();
        expect_period(W, 2 * P, 2 * P - W, "R3");
        expect_period(W, 2 * P, 2 * P - W, "R3");
        drain();
        half_rate_i = 1'b0;

        // no trip: switch stays on the whole period (R5)
        trip_i = 1'b0;
        settle();
        expect_period(P, P, 0, "R5");
        drain();

        // trip rises in period cycle 12: on for 12 + 3 cycles (R5)
        wait_tick();
        expect_period(15, P, P - 15, "R5");
        repeat (12) @(posedge clk);
        #2 trip_i = 1'b1;
        drain();

        // phase restart at period cycle 10 (R8)
        settle();
        expect_period(W, 11, 3, "R8");
        expect_period(W, P, P - W, "R8");
        repeat (10) @(posedge clk);
        #2 phase_step_i = 1'b1;
        @(posedge clk); #2 phase_step_i = 1'b0;
        drain();

        // open loop codes, rate bit set but ignored (R6, R3)
        open_loop_i = 1'b1;
        half_rate_i = 1'b1;
        for (int c = 0; c < 4; c++) begin
            on_code_i = 2'(c);
            settle();
            expect_period(on_tab[c], P, (c == 3) ? 0 : P - on_tab[c], (c == 0) ? "R3" : "R6");
            expect_period(on_tab[c], P, (c == 3) ? 0 : P - on_tab[c], "R6");
            drain();
        end
        open_loop_i = 1'b0;
        half_rate_i = 1'b0;
        on_code_i   = 2'd0;
        settle();

        // disable and release (R1)
        drive_off_i = 1'b1;
        @(posedge clk); @(negedge clk);
        check(!hs_on_o && !ls_assist_o, "R1 off", int'({hs_on_o, ls_assist_o}), 0);
        begin
            int ticks = 0;
            for (int i = 0; i < 3 * P; i++) begin
                @(negedge clk);
                ticks += int'(period_tick_o) + int'(hs_on_o);
            end
            check(ticks == 0, "R1 parked", ticks, 0);
        end
        @(posedge clk); #2 drive_off_i = 1'b0;
        @(posedge clk); @(negedge clk);
        check(hs_on_o && period_tick_o, "R1 release", int'({hs_on_o, period_tick_o}), 3);

        // reference selection (R9)
        for (int c = 0; c < 4; c++) begin
            @(posedge clk); #2 reduce_i = 1'b1; level_code_i = 2'(c);
            @(posedge clk); @(negedge clk);
            check(ref_mv_o == 10'(mv_tab[c]), "R9 reduced", int'(ref_mv_o), mv_tab[c]);
        end
        @(posedge clk); #2 reduce_i = 1'b0;
        @(posedge clk); @(negedge clk);
        check(ref_mv_o == 10'd500, "R9 nominal", int'(ref_mv_o), 500);

        summary();
        $finish;
    end

endmodule